// File: doc/BRIEF.md
# Converter Power and Reference Sequencer

This block decides when a serial sampling converter and its on-chip voltage reference draw power. A bus front end, outside this block, decodes the two-wire protocol and hands over single-cycle strobes. One says that a byte carrying this device's address has been taken in, and comes with the read/write bit of that byte. One marks the end of a conversion. One reports that the master declined a result byte with a not-acknowledge. A static input selects between the internal reference and one supplied from outside. The block drives an enable for the converter core, an enable for the internal reference, and a flag that tells when the reference has had time to settle.

The converter core is powered only while a conversion runs. The reference works on a slower rhythm. A read/write bit of 1 keeps it powered between conversions. A bit of 0 only arms it for shutdown. An armed reference stays up until the master ends the result read with a not-acknowledge, so the last conversion is not disturbed. When the reference is started from the off state, a timer measured in system clock cycles holds the ready flag low for the settle interval. The conversion that woke the reference therefore runs against an unsettled reference and is a throwaway. In external-reference mode the internal reference stays off and the read/write bit has no meaning.

Top module: `adcpwr_seq`

## Requirements
- R1: Synchronous active-high reset drives conv_en, ref_en and ref_ready to 0, and they are 0 in the first cycle after reset is released.
- R2: An addr_hit strobe sets conv_en to 1 in the cycle after the strobe.
- R3: A conv_done strobe clears conv_en in the cycle after it. If addr_hit arrives in the same cycle, conv_en stays 1.
- R4: With ext_ref_mode = 0, addr_hit sets ref_en to 1 in the next cycle. With rw_bit = 1, ref_en then stays 1 through conv_done and master_nack strobes.
- R5: With ext_ref_mode = 0, addr_hit with rw_bit = 0 arms shutdown. An armed reference stays on through conv_done and turns off in the cycle after a master_nack. A later addr_hit with rw_bit = 1 disarms it.
- R6: With ext_ref_mode = 1, ref_en and ref_ready are 0 in every cycle after the one in which the mode is first seen. rw_bit has no effect, and conv_en still follows R2 and R3.
- R7: ref_ready rises exactly SETTLE_CYC clock cycles after ref_en rises, where SETTLE_CYC = CLK_FREQ_HZ / 1000 × SETTLE_MS. It is 0 while the count runs and returns to 0 in the same cycle that ref_en falls.
- R8: An addr_hit while the settle count runs does not restart the count. ref_ready still rises SETTLE_CYC cycles after the first start, and conv_en still rises.
- R9: A master_nack when shutdown is not armed changes neither ref_en nor ref_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_hit | input | 1 | Single-cycle strobe: valid device address received |
| rw_bit | input | 1 | Read/write bit of the address byte, valid with addr_hit |
| conv_done | input | 1 | Single-cycle strobe: conversion finished |
| master_nack | input | 1 | Single-cycle strobe: master not-acknowledged a result byte |
| ext_ref_mode | input | 1 | 1 = external reference, 0 = internal reference |
| conv_en | output | 1 | Converter core power enable |
| ref_en | output | 1 | Internal reference power enable |
| ref_ready | output | 1 | Reference settle interval has elapsed |

## Verification
The checker watches the state relations on every cycle:
- the reset state after release;
- conv_en and ref_en following their strobes one cycle later;
- ref_ready never high without ref_en;
- ref_ready never dropping while the reference stays on;
- the reference staying off in external mode;
- ref_en surviving a strobe that must not turn it off.

The exact length of the settle window can only be shown by the bench's scenarios. The same holds for the timer not restarting on a second address, the arm and disarm history carried by the read/write bit across several transactions, and the priority of a same-cycle address over conv_done.

// File: rtl/adcpwr_pkg.sv
package adcpwr_pkg;

  typedef enum logic {
    REF_OFF = 1'b0,
    REF_ON  = 1'b1
  } ref_state_e;

  // Settle length in clock cycles, never below one
  function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                input int unsigned ms);
    int unsigned n;
    n = (clk_hz / 1000) * ms;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/adcpwr_core_gate.sv
module adcpwr_core_gate (
  input  logic clk,
  input  logic rst,
  input  logic addr_hit,
  input  logic conv_done,
  output logic conv_en
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (addr_hit) begin
      en_q <= 1'b1;
    end else if (conv_done) begin
      en_q <= 1'b0;
    end
  end

  assign conv_en = en_q;

endmodule

// File: rtl/adcpwr_ref_ctrl.sv
module adcpwr_ref_ctrl
  import adcpwr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic addr_hit,
  input  logic rw_bit,
  input  logic master_nack,
  input  logic ext_ref_mode,
  output logic ref_en,
  output logic ref_start,
  output logic ref_stop
);

  ref_state_e state_q;
  logic       armed_q;

  always_comb begin
    ref_start = addr_hit && !ext_ref_mode && (state_q == REF_OFF);
    ref_stop  = (state_q == REF_ON) &&
                (ext_ref_mode || (master_nack && armed_q && !addr_hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= REF_OFF;
      armed_q <= 1'b0;
    end else if (ext_ref_mode) begin
      state_q <= REF_OFF;
      armed_q <= 1'b0;
    end else if (addr_hit) begin
      state_q <= REF_ON;
      armed_q <= !rw_bit;
    end else if (master_nack && armed_q) begin
      state_q <= REF_OFF;
      armed_q <= 1'b0;
    end
  end

  assign ref_en = (state_q == REF_ON);

endmodule

// File: rtl/adcpwr_settle_timer.sv
module adcpwr_settle_timer #(
  parameter int unsigned SETTLE_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  output logic ready
);

  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (start) begin
      cnt_q <= CW'(SETTLE_CYC);
      rdy_q <= 1'b0;
    end else if (cnt_q > CW'(1)) begin
      cnt_q <= cnt_q - CW'(1);
    end else if (cnt_q == CW'(1)) begin
      cnt_q <= '0;
      rdy_q <= 1'b1;
    end
  end

  assign ready = rdy_q;

endmodule

// File: rtl/adcpwr_seq.sv
module adcpwr_seq
  import adcpwr_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 250_000_000,
  parameter int unsigned SETTLE_MS   = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_hit,
  input  logic rw_bit,
  input  logic conv_done,
  input  logic master_nack,
  input  logic ext_ref_mode,
  output logic conv_en,
  output logic ref_en,
  output logic ref_ready
);

  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_FREQ_HZ, SETTLE_MS);

  logic ref_start;
  logic ref_stop;

  adcpwr_core_gate u_core (
    .clk       (clk),
    .rst       (rst),
    .addr_hit  (addr_hit),
    .conv_done (conv_done),
    .conv_en   (conv_en)
  );

  adcpwr_ref_ctrl u_ref (
    .clk          (clk),
    .rst          (rst),
    .addr_hit     (addr_hit),
    .rw_bit       (rw_bit),
    .master_nack  (master_nack),
    .ext_ref_mode (ext_ref_mode),
    .ref_en       (ref_en),
    .ref_start    (ref_start),
    .ref_stop     (ref_stop)
  );

  adcpwr_settle_timer #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (ref_start),
    .stop  (ref_stop),
    .ready (ref_ready)
  );

endmodule

// File: rtl/adcpwr_seq_chk.sv
module adcpwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic addr_hit,
  input logic rw_bit,
  input logic conv_done,
  input logic master_nack,
  input logic ext_ref_mode,
  input logic conv_en,
  input logic ref_en,
  input logic ref_ready
);

  // R1: outputs still in the reset state in the first cycle after release
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!conv_en && !ref_en && !ref_ready));

  // R2
  a_r2_conv_up: assert property (@(posedge clk) disable iff (rst)
    addr_hit |=> conv_en);

  // R3
  a_r3_conv_down: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !addr_hit) |=> !conv_en);

  // R4
  a_r4_ref_up: assert property (@(posedge clk) disable iff (rst)
    (addr_hit && !ext_ref_mode) |=> ref_en);

  // R4: outside external mode, only master_nack may turn the reference off
  a_r4_ref_held: assert property (@(posedge clk) disable iff (rst)
    (ref_en && !master_nack && !ext_ref_mode) |=> ref_en);

  // R6
  a_r6_ext_off: assert property (@(posedge clk) disable iff (rst)
    ext_ref_mode |=> (!ref_en && !ref_ready));

  // R7
  a_r7_ready_needs_ref: assert property (@(posedge clk) disable iff (rst)
    ref_ready |-> ref_en);

  // R8: a settled reference stays settled while it stays on
  a_r8_ready_kept: assert property (@(posedge clk) disable iff (rst)
    ref_ready |=> (ref_ready || !ref_en));

endmodule

bind adcpwr_seq adcpwr_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .addr_hit     (addr_hit),
  .rw_bit       (rw_bit),
  .conv_done    (conv_done),
  .master_nack  (master_nack),
  .ext_ref_mode (ext_ref_mode),
  .conv_en      (conv_en),
  .ref_en       (ref_en),
  .ref_ready    (ref_ready)
);

// File: tb/adcpwr_seq_test.sv
module adcpwr_seq_test;

  localparam int unsigned CLK_HZ = 10_000;
  localparam int unsigned SET_MS = 2;
  localparam int unsigned N      = (CLK_HZ / 1000) * SET_MS;  // 20 cycles

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_hit = 1'b0, rw_bit = 1'b0, conv_done = 1'b0;
  logic master_nack = 1'b0, ext_ref_mode = 1'b0;
  logic conv_en, ref_en, ref_ready;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  adcpwr_seq #(.CLK_FREQ_HZ(CLK_HZ), .SETTLE_MS(SET_MS)) uut (
    .clk(clk), .rst(rst), .addr_hit(addr_hit), .rw_bit(rw_bit),
    .conv_done(conv_done), .master_nack(master_nack),
    .ext_ref_mode(ext_ref_mode), .conv_en(conv_en), .ref_en(ref_en),
    .ref_ready(ref_ready)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobes drive at a falling edge, so outputs are sampled one edge later
  task automatic send_addr(input logic rw);
    rw_bit = rw; addr_hit = 1'b1;
    @(negedge clk);
    addr_hit = 1'b0; rw_bit = 1'b0;
  endtask

  task automatic send_done();
    conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic send_nack();
    master_nack = 1'b1; @(negedge clk); master_nack = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wait_n(2); rst = 1'b0; wait_n(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 conv_en after reset", conv_en, 1'b0);
    chk("R1 ref_en after reset", ref_en, 1'b0);
    chk("R1 ref_ready after reset", ref_ready, 1'b0);
  endtask

  task automatic t_keep_on();
    send_addr(1'b1);
    chk("R2 conv_en after addr", conv_en, 1'b1);
    chk("R4 ref_en after addr", ref_en, 1'b1);
    chk("R7 ready low at start", ref_ready, 1'b0);
    wait_n(N - 1);
    chk("R7 ready low one cycle early", ref_ready, 1'b0);
    wait_n(1);
    chk("R7 ready high after settle", ref_ready, 1'b1);
    send_done();
    chk("R3 conv_en after done", conv_en, 1'b0);
    chk("R4 ref kept after done", ref_en, 1'b1);
    send_nack();
    chk("R9 ref kept after unarmed nack", ref_en, 1'b1);
    chk("R9 ready kept after unarmed nack", ref_ready, 1'b1);
  endtask

  task automatic t_armed_off();
    send_addr(1'b0);
    chk("R5 ref on while armed", ref_en, 1'b1);
    chk("R8 no restart on addr when ready", ref_ready, 1'b1);
    send_done();
    chk("R5 armed ref survives done", ref_en, 1'b1);
    send_nack();
    chk("R5 ref off after armed nack", ref_en, 1'b0);
    chk("R7 ready cleared with ref", ref_ready, 1'b0);
  endtask

  task automatic t_disarm();
    send_addr(1'b0);
    send_addr(1'b1);
    send_nack();
    chk("R5 disarmed ref survives nack", ref_en, 1'b1);
  endtask

  task automatic t_mid_settle();
    do_reset();
    send_addr(1'b1);
    wait_n(5);
    send_done();
    send_addr(1'b1);
    chk("R8 conv_en on second addr", conv_en, 1'b1);
    chk("R8 ready low mid settle", ref_ready, 1'b0);
    wait_n(N - 8);
    chk("R8 ready low before first window ends", ref_ready, 1'b0);
    wait_n(1);
    chk("R8 ready from first start", ref_ready, 1'b1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    send_addr(1'b1);
    addr_hit = 1'b1; conv_done = 1'b1; rw_bit = 1'b1;
    @(negedge clk);
    addr_hit = 1'b0; conv_done = 1'b0; rw_bit = 1'b0;
    chk("R3 addr wins over done", conv_en, 1'b1);
  endtask

  task automatic t_external();
    ext_ref_mode = 1'b1;
    wait_n(1);
    chk("R6 ref off in ext mode", ref_en, 1'b0);
    send_addr(1'b1);
    chk("R6 conv_en in ext mode", conv_en, 1'b1);
    chk("R6 ref off with rw=1", ref_en, 1'b0);
    send_addr(1'b0);
    chk("R6 ref off with rw=0", ref_en, 1'b0);
    wait_n(N + 2);
    chk("R6 ready stays low", ref_ready, 1'b0);
    ext_ref_mode = 1'b0;
    wait_n(1);
    send_nack();
    chk("R9 nack leaves ref off", ref_en, 1'b0);
    send_addr(1'b1);
    rst = 1'b1; wait_n(1); rst = 1'b0; wait_n(1);
    chk("R1 reset mid operation conv", conv_en, 1'b0);
    chk("R1 reset mid operation ref", ref_en, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_keep_on();
        t_armed_off();
        t_disarm();
        t_mid_settle();
        t_same_cycle();
        t_external();
      end
      begin
        wait_n(20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule